// File: doc/BRIEF.md
# Asynchronous DRAM Target Model

This block is a synthesizable stand-in for a 16-bit asynchronous DRAM. It sits where a real memory part would sit, so that a DRAM controller can be exercised against it in simulation or on a prototype. The controller drives an active-low row strobe, two active-low column strobes (one per byte), a write enable, an output enable and a 9-bit multiplexed address. The model answers on a split data port: a 16-bit input bus, a 16-bit output bus and one drive enable per byte lane.

A fast sampling clock registers every strobe, and edges are found by comparing each sample with the previous one, so the model is fully synchronous. A row is captured when the row strobe falls and a column when the merged column strobe falls. Reads and writes work per byte lane. A row strobe that falls while a column strobe is already low starts a refresh-only cycle that takes its row from an internal counter. Every row strobe fall reports the refreshed row on a one-cycle pulse. Two error pulses report row-strobe timing violations and accesses made during the power-up warm-up cycles. The array is smaller than the full address space: only the low row and column bits index it, and the upper bits alias.

Top module: `adram_target`

## Requirements
- R1: The merged column strobe goes active when the first of `casLoN`/`casUpN` goes low and inactive only when both are high again. The column address is captured only when the merged strobe falls, so a second lane strobe falling later reuses the column already captured.
- R2: The row address is captured from `addr` on the sample where `rasN` falls (non-refresh cycles), and the column on the merged strobe fall. The array is indexed by row bits [ROW_BITS-1:0] above column bits [COL_BITS-1:0], and higher address bits are ignored (aliasing).
- R3: `dqOe[0]` (bits 7:0) is high only while `casLoN`, `oeN` and `rasN` are low and `weN` is high in a non-refresh cycle, and `dqOe[1]` (bits 15:8) likewise with `casUpN`. An undriven lane of `dqOut` reads zero. Outputs follow a port change after two sampling-clock edges, and the reset state has both enables low.
- R4: A write happens at the later of a lane's column strobe fall and the `weN` fall. It stores `dqIn` only into lanes whose column strobe is low, and other lanes keep their contents.
- R5: When a column strobe is already low as `rasN` falls, the cycle is refresh-only. `addr` is ignored, `refreshRow` reports the internal counter, no lane is driven even with `oeN` low, and nothing is written even with `weN` low.
- R6: Every `rasN` fall produces a one-cycle `refreshStb` pulse. In non-refresh cycles `refreshRow` carries the full 9-bit row address.
- R7: A read or write inside any of the first INIT_CYC (default 8) row-strobe cycles after reset produces an `earlyErr` pulse. Accesses in later cycles produce none.
- R8: The internal refresh row counter starts at 0 after reset, advances by one after each refresh-only cycle, and wraps from 511 to 0.
- R9: `timingErr` pulses when `rasN` rises after fewer than MIN_ACT (default 4) low samples, or falls after fewer than MIN_PRE (default 3) high samples. Exactly MIN_ACT low or MIN_PRE high samples give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row strobe, active low |
| casLoN | input | 1 | Column strobe for bits 7:0, active low |
| casUpN | input | 1 | Column strobe for bits 15:8, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| dqIn | input | 16 | Data from the controller |
| dqOut | output | 16 | Data to the controller, zero in undriven lanes |
| dqOe | output | 2 | Per-lane drive enable (bit 0 = low byte) |
| refreshStb | output | 1 | One-cycle pulse per row strobe fall |
| refreshRow | output | 9 | Row refreshed by the latest row strobe fall |
| timingErr | output | 1 | Row-strobe active/precharge violation pulse |
| earlyErr | output | 1 | Access during warm-up pulse |

## Verification
The assertions check on every cycle that a lane drive enable only follows the right combination of port strobes two samples earlier, and that a refresh-only cycle never drives the bus. They also check that each refresh-only cycle steps the row counter by one and reports the previous count, and that a timing pulse only follows a real row-strobe edge. Byte-lane merging, column reuse under a second strobe, address aliasing, write masking, the warm-up window, the exact timing boundaries and the counter wrap after 512 refresh cycles need a stored value or a long history. Only the bench's directed scenarios, checked against a reference array, can show those.

// File: rtl/adram_pkg.sv
`timescale 1ns/1ps
package adram_pkg;
  localparam int ADDR_W = 9;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // Per-sample event strobes from control to datapath
  typedef struct packed {
    logic             rasFall;   // row strobe fell on this sample
    logic             rowLatch;  // capture row (normal cycle)
    logic             cbrStart;  // refresh-only cycle begins
    logic             colLatch;  // merged column strobe fell
    logic [LANES-1:0] laneWr;    // write this lane now
    logic [LANES-1:0] laneRd;    // lane drive condition
  } strobe_t;
endpackage

// File: rtl/adram_strobe_ctrl.sv
`timescale 1ns/1ps
module adram_strobe_ctrl
  import adram_pkg::*;
#(
  parameter int MIN_ACT  = 4,
  parameter int MIN_PRE  = 3,
  parameter int INIT_CYC = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rasN,
  input  logic [LANES-1:0] casN,
  input  logic             weN,
  input  logic             oeN,
  output strobe_t          stb,
  output logic             timingErr,
  output logic             earlyErr
);
  localparam int TMAX = (MIN_ACT > MIN_PRE) ? MIN_ACT : MIN_PRE;
  localparam int TW   = $clog2(TMAX + 1) + 1;
  localparam int IW   = $clog2(INIT_CYC + 2);
  localparam logic [TW-1:0] ACT_LIM  = TW'(MIN_ACT);
  localparam logic [TW-1:0] PRE_LIM  = TW'(MIN_PRE);
  localparam logic [TW-1:0] SAT_LIM  = TW'(TMAX);
  localparam logic [IW-1:0] INIT_LIM = IW'(INIT_CYC);

  // Sampled strobes
  logic             rasS, rasP, weS, oeS;
  logic [LANES-1:0] casS;
  logic             casActP;
  logic             cbrReg;
  logic [LANES-1:0] wrCondP, rdCondP;
  logic [TW-1:0]    actCnt, preCnt;
  logic [IW-1:0]    initCnt;

  logic             rasAct, rasFall, rasRise, casAct, inCycle, access;
  logic [LANES-1:0] laneAct, wrCond, rdCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasS    <= 1'b1;
      rasP    <= 1'b1;
      casS    <= '1;
      weS     <= 1'b1;
      oeS     <= 1'b1;
      casActP <= 1'b0;
    end else begin
      rasS    <= rasN;
      rasP    <= rasS;
      casS    <= casN;
      weS     <= weN;
      oeS     <= oeN;
      casActP <= casAct;
    end
  end

  assign rasAct  = ~rasS;
  assign rasFall = rasP & ~rasS;
  assign rasRise = ~rasP & rasS;
  assign laneAct = ~casS;
  assign casAct  = |laneAct;
  assign inCycle = rasAct & ~rasFall & ~cbrReg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wrCond[g] = inCycle & laneAct[g] & ~weS;
    assign rdCond[g] = inCycle & laneAct[g] & ~oeS & weS;
  end

  assign stb.rasFall  = rasFall;
  assign stb.rowLatch = rasFall & ~casAct;
  assign stb.cbrStart = rasFall & casAct;
  assign stb.colLatch = casAct & ~casActP;
  assign stb.laneWr   = wrCond & ~wrCondP;
  assign stb.laneRd   = rdCond;

  assign access = (|(wrCond & ~wrCondP)) | (|(rdCond & ~rdCondP));

  // Cycle kind and lane history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cbrReg  <= 1'b0;
      wrCondP <= '0;
      rdCondP <= '0;
    end else begin
      if (rasFall) cbrReg <= casAct;
      wrCondP <= wrCond;
      rdCondP <= rdCond;
    end
  end

  // Row-strobe active / precharge length checks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actCnt    <= '0;
      preCnt    <= SAT_LIM;
      timingErr <= 1'b0;
    end else if (rasFall) begin
      timingErr <= (preCnt < PRE_LIM);
      actCnt    <= TW'(1);
    end else if (rasRise) begin
      timingErr <= (actCnt < ACT_LIM);
      preCnt    <= TW'(1);
    end else begin
      timingErr <= 1'b0;
      if (rasAct && actCnt < SAT_LIM) actCnt <= actCnt + TW'(1);
      if (!rasAct && preCnt < SAT_LIM) preCnt <= preCnt + TW'(1);
    end
  end

  // Warm-up cycle counting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt  <= '0;
      earlyErr <= 1'b0;
    end else begin
      if (rasFall && initCnt <= INIT_LIM) initCnt <= initCnt + IW'(1);
      earlyErr <= access && (initCnt <= INIT_LIM);
    end
  end
endmodule

// File: rtl/adram_store.sv
`timescale 1ns/1ps
module adram_store
  import adram_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic [LANES-1:0]  dqOe,
  output logic              refreshStb,
  output logic [ADDR_W-1:0] refreshRow,
  output logic [ADDR_W-1:0] refCnt
);
  localparam int IDX_W = ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << IDX_W;

  logic [ADDR_W-1:0]   addrS;
  logic [DATA_W-1:0]   dinS;
  logic [ROW_BITS-1:0] rowReg;
  logic [COL_BITS-1:0] colReg, effCol;
  logic [IDX_W-1:0]    wrIdx, rdIdx;
  logic [DATA_W-1:0]   mem [DEPTH];
  logic [DATA_W-1:0]   rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrS <= '0;
      dinS  <= '0;
    end else begin
      addrS <= addr;
      dinS  <= dqIn;
    end
  end

  assign effCol = stb.colLatch ? addrS[COL_BITS-1:0] : colReg;
  assign wrIdx  = {rowReg, effCol};
  assign rdIdx  = {rowReg, colReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg <= '0;
      colReg <= '0;
      dqOe   <= '0;
    end else begin
      if (stb.rowLatch) rowReg <= addrS[ROW_BITS-1:0];
      if (stb.colLatch) colReg <= addrS[COL_BITS-1:0];
      dqOe <= stb.laneRd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (stb.laneWr[l]) mem[wrIdx][l*LANE_W +: LANE_W] <= dinS[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rdWord = mem[rdIdx];

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign dqOut[g*LANE_W +: LANE_W] = dqOe[g] ? rdWord[g*LANE_W +: LANE_W] : '0;
  end

  // Refresh reporting and internal row counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refreshStb <= 1'b0;
      refreshRow <= '0;
      refCnt     <= '0;
    end else begin
      refreshStb <= stb.rasFall;
      if (stb.rasFall) refreshRow <= stb.cbrStart ? refCnt : addrS;
      if (stb.cbrStart) refCnt <= refCnt + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/adram_target.sv
`timescale 1ns/1ps
module adram_target
  import adram_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int MIN_ACT  = 4,
  parameter int MIN_PRE  = 3,
  parameter int INIT_CYC = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rasN,
  input  logic        casLoN,
  input  logic        casUpN,
  input  logic        weN,
  input  logic        oeN,
  input  logic [8:0]  addr,
  input  logic [15:0] dqIn,
  output logic [15:0] dqOut,
  output logic [1:0]  dqOe,
  output logic        refreshStb,
  output logic [8:0]  refreshRow,
  output logic        timingErr,
  output logic        earlyErr
);
  strobe_t           stb;
  logic [ADDR_W-1:0] refCnt;

  adram_strobe_ctrl #(
    .MIN_ACT (MIN_ACT),
    .MIN_PRE (MIN_PRE),
    .INIT_CYC(INIT_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rasN     (rasN),
    .casN     ({casUpN, casLoN}),
    .weN      (weN),
    .oeN      (oeN),
    .stb      (stb),
    .timingErr(timingErr),
    .earlyErr (earlyErr)
  );

  adram_store #(
    .ROW_BITS(ROW_BITS),
    .COL_BITS(COL_BITS)
  ) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .addr      (addr),
    .dqIn      (dqIn),
    .dqOut     (dqOut),
    .dqOe      (dqOe),
    .refreshStb(refreshStb),
    .refreshRow(refreshRow),
    .refCnt    (refCnt)
  );
endmodule

// File: rtl/adram_target_chk.sv
`timescale 1ns/1ps
module adram_target_chk
  import adram_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        rasN,
  input logic        casLoN,
  input logic        casUpN,
  input logic        weN,
  input logic        oeN,
  input logic [1:0]  dqOe,
  input strobe_t     stb,
  input logic [8:0]  refCnt,
  input logic        refreshStb,
  input logic [8:0]  refreshRow,
  input logic        timingErr
);
  AST_LO_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    dqOe[0] |-> ($past(!casLoN, 2) && $past(!oeN, 2) && $past(weN, 2) && $past(!rasN, 2))); // R3
  AST_UP_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    dqOe[1] |-> ($past(!casUpN, 2) && $past(!oeN, 2) && $past(weN, 2) && $past(!rasN, 2))); // R3
  AST_REFRESH_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    stb.cbrStart |=> (dqOe == 2'b00)); // R5
  AST_REFRESH_ROW_SRC: assert property (@(posedge clk) disable iff (!rstN)
    stb.cbrStart |=> (refreshStb && refreshRow == $past(refCnt))); // R5
  AST_REFCNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.cbrStart |=> (refCnt == $past(refCnt) + 9'd1)); // R8
  AST_TERR_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    timingErr |-> ($past(rasN, 2) != $past(rasN, 3))); // R9
endmodule

bind adram_target adram_target_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rasN      (rasN),
  .casLoN    (casLoN),
  .casUpN    (casUpN),
  .weN       (weN),
  .oeN       (oeN),
  .dqOe      (dqOe),
  .stb       (stb),
  .refCnt    (refCnt),
  .refreshStb(refreshStb),
  .refreshRow(refreshRow),
  .timingErr (timingErr)
);

// File: tb/test_adram_target.sv
`timescale 1ns/1ps
module test_adram_target;
  localparam int ROWB = 3;
  localparam int COLB = 3;
  localparam int MA   = 4;
  localparam int MP   = 3;
  localparam int IC   = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rasN = 1'b1, casLoN = 1'b1, casUpN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] dqIn = '0;
  logic [15:0] dqOut;
  logic [1:0]  dqOe;
  logic        refreshStb;
  logic [8:0]  refreshRow;
  logic        timingErr, earlyErr;

  int checks = 0;
  int fails  = 0;
  int refSeen = 0, tErrSeen = 0, eErrSeen = 0;
  logic [8:0]  lastRow = '0;
  logic [8:0]  expRef = '0;
  logic [15:0] model [1 << (ROWB + COLB)];

  always #10 clk = ~clk;

  adram_target #(
    .ROW_BITS(ROWB), .COL_BITS(COLB), .MIN_ACT(MA), .MIN_PRE(MP), .INIT_CYC(IC)
  ) i_adram_target (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casLoN(casLoN), .casUpN(casUpN),
    .weN(weN), .oeN(oeN), .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe),
    .refreshStb(refreshStb), .refreshRow(refreshRow),
    .timingErr(timingErr), .earlyErr(earlyErr)
  );

  // Pulse monitors
  always @(negedge clk) begin
    if (rstN) begin
      if (refreshStb) begin refSeen++; lastRow = refreshRow; end
      if (timingErr) tErrSeen++;
      if (earlyErr) eErrSeen++;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int idx(input logic [8:0] row, input logic [8:0] col);
    return int'({row[ROWB-1:0], col[COLB-1:0]});
  endfunction

  task automatic openRow(input logic [8:0] row);
    addr = row; rasN = 1'b0; tick(2);
  endtask

  task automatic closeRow();
    casLoN = 1'b1; casUpN = 1'b1; weN = 1'b1; oeN = 1'b1; tick(MA);
    rasN = 1'b1; tick(MP + 1);
  endtask

  task automatic doWrite(input logic [8:0] row, input logic [8:0] col, input logic [15:0] d, input logic [1:0] lanes);
    openRow(row);
    addr = col; dqIn = d; weN = 1'b0; casLoN = ~lanes[0]; casUpN = ~lanes[1]; tick(2);
    closeRow();
    if (lanes[0]) model[idx(row, col)][7:0]  = d[7:0];
    if (lanes[1]) model[idx(row, col)][15:8] = d[15:8];
  endtask

  task automatic doRead(input logic [8:0] row, input logic [8:0] col, output logic [15:0] rd, output logic [1:0] oe);
    openRow(row);
    addr = col; casLoN = 1'b0; casUpN = 1'b0; oeN = 1'b0; tick(3);
    rd = dqOut; oe = dqOe;
    closeRow();
  endtask

  task automatic rasOnly(input logic [8:0] row);
    openRow(row); closeRow();
  endtask

  task automatic refreshCycle(input logic [8:0] junk, input logic wLow, input logic oLow, output logic [1:0] oeMid);
    casLoN = 1'b0; addr = junk; weN = wLow; oeN = oLow; dqIn = 16'hDEAD; tick(1);
    rasN = 1'b0; tick(MA + 1);
    oeMid = dqOe;
    rasN = 1'b1; tick(1);
    casLoN = 1'b1; weN = 1'b1; oeN = 1'b1; tick(MP + 1);
    expRef = expRef + 9'd1;
  endtask

  task automatic t_reset();
    check(dqOe == 2'b00, "R3 reset dqOe", 32'(dqOe), 0);
    check(dqOut == 16'h0, "R3 reset dqOut", 32'(dqOut), 0);
    check(refreshStb == 1'b0 && timingErr == 1'b0 && earlyErr == 1'b0, "R9 reset pulses",
          {29'd0, refreshStb, timingErr, earlyErr}, 0);
  endtask

  task automatic t_init();
    int r0;
    doWrite(9'd1, 9'd1, 16'h5A5A, 2'b11);
    check(eErrSeen == 1, "R7 access in first cycle flagged", 32'(eErrSeen), 1);
    for (int k = 2; k <= IC; k++) begin
      r0 = refSeen;
      rasOnly(9'(k * 37));
      check(refSeen == r0 + 1 && lastRow == 9'(k * 37), "R6 ras-only refresh row", 32'(lastRow), 32'(9'(k * 37)));
    end
    doWrite(9'd1, 9'd2, 16'h0F0F, 2'b11);
    check(eErrSeen == 1, "R7 access after warm-up not flagged", 32'(eErrSeen), 1);
    check(lastRow == 9'd1, "R6 write cycle refresh row", 32'(lastRow), 1);
    check(tErrSeen == 0, "R9 no timing error in legal cycles", 32'(tErrSeen), 0);
  endtask

  task automatic t_rw();
    logic [15:0] rd; logic [1:0] oe;
    doWrite(9'd3, 9'd4, 16'h1234, 2'b11);
    doWrite(9'd3, 9'd4, 16'hFFEE, 2'b01);
    doRead(9'd3, 9'd4, rd, oe);
    check(rd == 16'h12EE, "R4 low lane only written", 32'(rd), 32'h12EE);
    check(oe == 2'b11, "R3 both lanes driven on read", 32'(oe), 3);
    doWrite(9'd3, 9'd4, 16'h77AA, 2'b10);
    doRead(9'd3, 9'd4, rd, oe);
    check(rd == 16'h77EE, "R4 high lane only written", 32'(rd), 32'h77EE);
    doWrite(9'h103, 9'h1F4, 16'hBEEF, 2'b11);
    doRead(9'd3, 9'd4, rd, oe);
    check(rd == 16'hBEEF, "R2 upper address bits alias", 32'(rd), 32'hBEEF);
    doRead(9'd1, 9'd1, rd, oe);
    check(rd == model[idx(9'd1, 9'd1)], "R2 row/col placement", 32'(rd), 32'(model[idx(9'd1, 9'd1)]));
    doRead(9'd2, 9'd7, rd, oe);
    check(rd == 16'h0, "R2 untouched location", 32'(rd), 0);
  endtask

  task automatic t_merge();
    logic [15:0] rd; logic [1:0] oe;
    openRow(9'd5);
    addr = 9'd1; dqIn = 16'hA5C3; weN = 1'b0; casLoN = 1'b0; tick(2);
    addr = 9'd6; casUpN = 1'b0; tick(2);
    closeRow();
    model[idx(9'd5, 9'd1)] = 16'hA5C3;
    doRead(9'd5, 9'd1, rd, oe);
    check(rd == 16'hA5C3, "R1 second strobe reuses first column", 32'(rd), 32'hA5C3);
    doRead(9'd5, 9'd6, rd, oe);
    check(rd == 16'h0000, "R1 later address not captured", 32'(rd), 0);
  endtask

  task automatic t_lanes();
    openRow(9'd5);
    addr = 9'd1; casUpN = 1'b0; oeN = 1'b0; tick(1);
    check(dqOe == 2'b00, "R3 one edge not yet visible", 32'(dqOe), 0);
    tick(2);
    check(dqOe == 2'b10 && dqOut == 16'hA500, "R3 upper lane only",
          {14'd0, dqOe, dqOut}, {14'd0, 2'b10, 16'hA500});
    oeN = 1'b1; tick(2);
    check(dqOe == 2'b00 && dqOut == 16'h0, "R3 OE high releases bus", 32'(dqOe), 0);
    addr = 9'd6; oeN = 1'b0; casLoN = 1'b0; tick(2);
    check(dqOut == 16'hA5C3 && dqOe == 2'b11, "R1 strobe stays active, column held", 32'(dqOut), 32'hA5C3);
    casUpN = 1'b1; tick(2);
    check(dqOe == 2'b01 && dqOut == 16'h00C3, "R1 merged strobe held by last lane", 32'(dqOut), 32'h00C3);
    weN = 1'b0; casLoN = 1'b1; tick(2);
    check(dqOe == 2'b00, "R3 WE low blocks drive", 32'(dqOe), 0);
    closeRow();
  endtask

  task automatic t_refresh();
    logic [15:0] rd; logic [1:0] oe; logic [1:0] mid; int r0;
    r0 = refSeen;
    refreshCycle(9'd4, 1'b0, 1'b1, mid);
    check(refSeen == r0 + 1 && lastRow == 9'd0, "R5 refresh row from counter, address ignored", 32'(lastRow), 0);
    check(mid == 2'b00, "R5 no drive during refresh (WE low)", 32'(mid), 0);
    refreshCycle(9'd4, 1'b1, 1'b0, mid);
    check(mid == 2'b00, "R5 no drive during refresh (OE low)", 32'(mid), 0);
    check(lastRow == 9'd1, "R8 counter advanced", 32'(lastRow), 1);
    doRead(9'd3, 9'd4, rd, oe);
    check(rd == model[idx(9'd3, 9'd4)], "R5 refresh writes nothing", 32'(rd), 32'(model[idx(9'd3, 9'd4)]));
  endtask

  task automatic t_timing();
    int e0;
    e0 = tErrSeen;
    rasN = 1'b0; tick(MA - 1);
    rasN = 1'b1; tick(MP + 1);
    check(tErrSeen == e0 + 1, "R9 short active flagged", 32'(tErrSeen - e0), 1);
    e0 = tErrSeen;
    rasN = 1'b0; tick(MA);
    rasN = 1'b1; tick(1);
    rasN = 1'b0; tick(MA);
    rasN = 1'b1; tick(MP + 1);
    check(tErrSeen == e0 + 1, "R9 short precharge flagged, exact active ok", 32'(tErrSeen - e0), 1);
    e0 = tErrSeen;
    rasN = 1'b0; tick(MA);
    rasN = 1'b1; tick(MP);
    rasN = 1'b0; tick(MA);
    rasN = 1'b1; tick(MP + 1);
    check(tErrSeen == e0, "R9 exact minimum precharge ok", 32'(tErrSeen - e0), 0);
  endtask

  task automatic t_wrap();
    logic [1:0] mid; logic [8:0] want;
    while (expRef != 9'd511) refreshCycle(9'd0, 1'b1, 1'b1, mid);
    want = expRef;
    refreshCycle(9'd0, 1'b1, 1'b1, mid);
    check(lastRow == want, "R8 counter reaches 511", 32'(lastRow), 32'(want));
    refreshCycle(9'd0, 1'b1, 1'b1, mid);
    check(lastRow == 9'd0, "R8 counter wraps to 0", 32'(lastRow), 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << (ROWB + COLB)); i++) model[i] = '0;
    tick(3);
    t_reset();
    rstN = 1'b1;
    tick(2);
    t_init();
    t_rw();
    t_merge();
    t_lanes();
    t_refresh();
    t_timing();
    t_wrap();
    check(eErrSeen == 1, "R7 no further warm-up flags", 32'(eErrSeen), 1);
    summary();
  end
endmodule